// File: doc/BRIEF.md
# Variable-Pulse-Width Bit Codec

This block turns bytes into variable-pulse-width bus symbols and back. On the send side it takes bytes through a ready/valid handshake. It opens each frame with a start-of-frame pulse at the active level, then drives the data bits most significant first. The bus level alternates from one bit to the next, so every bit ends in exactly one transition. A bit is short or long depending on its value and on the level it is sent at.

On the receive side the block synchronizes the bus level and measures the time between edges in ticks. It sorts each period into noise, a short bit, a long bit, a start-of-frame pulse or an invalid symbol, shifts the decoded bits into a byte, and presents each finished byte with a one-cycle strobe. All timing counts the `tick` enable and not the clock. With a 1 us tick the default parameters give the nominal 10.4 kbps timing. CRC, end-of-data and frame spacing are left to the logic around the block.

Top module: `vpw_codec`

## Requirements
- R1: After reset, `bus_tx` is 0 (passive), `tx_ready` is 1, and `rx_valid` and `rx_invalid` are 0.
- R2: A byte accepted while the transmitter is idle starts a frame. The frame begins with a start pulse: `bus_tx` = 1 (active) for SOF_T ticks (default 200). The first data bit after the pulse is at the passive level.
- R3: Each transmitted bit lasts SHORT_T ticks (64) or LONG_T ticks (128): passive 1 is short, passive 0 is long, active 0 is short and active 1 is long. The level toggles once per bit, and bits go out MSB first.
- R4: If `tx_valid` is high in the cycle the eighth bit of a byte ends, that byte is accepted and its first bit follows at once, with no new start pulse. Otherwise the transmitter drives passive and returns to idle with `tx_ready` = 1.
- R5: Timing on both sides advances only in cycles where `tick` is 1. With a tick every D cycles, a bit of N ticks lasts N*D clock cycles.
- R6: A received period of w ticks is a short bit for 34 <= w < 96 and a long bit for 96 <= w < 163, and is decoded with the table of R3. An active period of 163 <= w < 239 is a start pulse and opens a frame. Bits are assembled MSB first.
- R7: The received byte appears on `rx_data` after its eighth bit, together with a `rx_valid` pulse of exactly one cycle.
- R8: A period shorter than 34 ticks is noise. It abandons the byte being assembled, raises no flag, and the receiver waits for the next start pulse.
- R9: An active period of 239 ticks or more gives a one-cycle `rx_invalid` pulse and abandons the frame. The data periods that follow produce no byte.
- R10: A passive period of 163 ticks or more ends the frame without a flag. Bit periods outside a frame are ignored until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base enable, one pulse per time unit |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Byte accepted in this cycle if `tx_valid` is high |
| bus_tx | output | 1 | Driven bus level, 1 = active |
| bus_rx | input | 1 | Observed bus level, asynchronous, 1 = active |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_invalid | output | 1 | One-cycle strobe for an over-long active symbol |

## Verification
A wrong transmit bit count or a wrong value in the duration counter shows up on `bus_tx` within one bit time, as a period of the wrong width or a missing toggle. The bench therefore records every level width and compares it with a table computed from R3. A stuck receive frame flag or bit counter does not show at once. It appears at the next eighth-bit boundary, within about one byte time, as a missing, extra or shifted `rx_data` byte. The bench drives period widths exactly at each window edge to separate off-by-one errors in the classifier.

// File: rtl/vpw_pkg.sv
// vpw_pkg: types and small helpers shared by the variable-pulse-width codec.
// Assumes the active bus level is encoded as 1 and the passive level as 0.
package vpw_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SOF,
        TX_DATA
    } tx_state_e;

    typedef enum logic [2:0] {
        PER_NOISE,
        PER_SHORT,
        PER_LONG,
        PER_SOF,
        PER_OVER
    } per_class_e;

    // A bit is long when its value equals the level it is sent at.
    function automatic logic vpw_is_long(input logic bit_val, input logic active);
        return bit_val == active;
    endfunction

    // Inverse mapping: recover the bit from its duration class and level.
    function automatic logic vpw_bit_value(input logic is_long, input logic active);
        return is_long ^ ~active;
    endfunction

endpackage

// File: rtl/vpw_tx.sv
// vpw_tx: serializes bytes into variable-pulse-width symbols.
// Sends a start pulse at the active level before the first byte of a frame,
// then alternates levels bit by bit, MSB first. Assumes each byte has eight
// bits, so every byte starts passive and ends active. A byte offered when
// the eighth bit ends continues the frame; otherwise the bus returns passive.
module vpw_tx
    import vpw_pkg::*;
#(
    parameter int SHORT_T = 64,
    parameter int LONG_T  = 128,
    parameter int SOF_T   = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       bus_tx
);

    localparam int TCW = $clog2(SOF_T + 1);

    tx_state_e      state;
    logic           level;
    logic [TCW-1:0] cnt;
    logic [7:0]     shreg;
    logic [2:0]     bitn;
    logic [TCW-1:0] dur;
    logic           period_end;
    logic           last_bit;
    logic           accept;

    // Select the length of the current period from state, bit and level.
    always_comb begin
        if (state == TX_SOF) begin
            dur = TCW'(SOF_T);
        end else if (vpw_is_long(shreg[7], level)) begin
            dur = TCW'(LONG_T);
        end else begin
            dur = TCW'(SHORT_T);
        end
    end

    // Period boundary, last-bit detection and the handshake window.
    always_comb begin
        period_end = tick && (cnt == dur - 1'b1);
        last_bit   = (bitn == 3'd7);
        tx_ready   = (state == TX_IDLE) || ((state == TX_DATA) && period_end && last_bit);
        accept     = tx_valid && tx_ready;
    end

    // Sequencer: start pulse, bit stepping, byte chaining and return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            level <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
            bitn  <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    cnt <= '0;
                    if (accept) begin
                        state <= TX_SOF;
                        level <= 1'b1;
                        shreg <= tx_data;
                        bitn  <= '0;
                    end
                end
                TX_SOF: begin
                    if (tick) begin
                        if (period_end) begin
                            state <= TX_DATA;
                            level <= 1'b0;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        if (period_end) begin
                            cnt   <= '0;
                            level <= ~level;
                            if (last_bit) begin
                                bitn <= '0;
                                if (accept) begin
                                    shreg <= tx_data;
                                end else begin
                                    state <= TX_IDLE;
                                end
                            end else begin
                                shreg <= {shreg[6:0], 1'b0};
                                bitn  <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign bus_tx = level;

    // The duration counter never reaches the length of its period.
    assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE) |-> (cnt < dur));

    // The start pulse always hands over to a passive first data bit.
    assert_sof_then_passive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SOF && period_end) |=> (state == TX_DATA && !bus_tx));

    // Every data period boundary flips the bus level.
    assert_level_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DATA && period_end) |=> (bus_tx != $past(bus_tx)));

endmodule

// File: rtl/vpw_edge_sync.sv
// vpw_edge_sync: brings the asynchronous bus level into the clock domain.
// Reports a transition and the level of the period that just ended.
// Assumes the bus holds each level for far longer than three clock cycles.
module vpw_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic edge_seen,
    output logic ended_level
);

    logic s1;
    logic s2;
    logic lvl_q;

    // Two-stage synchronizer plus a register holding the settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            lvl_q <= 1'b0;
        end else begin
            s1    <= bus_in;
            s2    <= s1;
            lvl_q <= s2;
        end
    end

    assign edge_seen   = (s2 != lvl_q);
    assign ended_level = lvl_q;

endmodule

// File: rtl/vpw_rx.sv
// vpw_rx: measures periods between bus edges in ticks, classifies them and
// assembles bytes MSB first. A frame opens on an active start pulse. Noise
// or a long passive gap closes it silently; an over-long active period
// closes it with an invalid strobe. Assumes edge_seen from vpw_edge_sync.
module vpw_rx
    import vpw_pkg::*;
#(
    parameter int NOISE_MIN = 34,
    parameter int LONG_MIN  = 96,
    parameter int SOF_MIN   = 163,
    parameter int SOF_MAX   = 239
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       edge_seen,
    input  logic       ended_level,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_invalid
);

    localparam int RCW = $clog2(SOF_MAX + 2);

    logic [RCW-1:0] cnt;
    logic [RCW:0]   width;
    per_class_e     pclass;
    logic           in_frame;
    logic [6:0]     shreg;
    logic [2:0]     bitn;
    logic           new_bit;

    // Saturating tick counter, restarted at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (edge_seen) begin
            cnt <= '0;
        end else if (tick && (cnt != RCW'(SOF_MAX))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Width of the finished period, including a tick in the edge cycle.
    always_comb begin
        width = {1'b0, cnt} + (RCW + 1)'(tick);
    end

    // Sort the finished period into its window.
    always_comb begin
        if (width < (RCW + 1)'(NOISE_MIN)) begin
            pclass = PER_NOISE;
        end else if (width < (RCW + 1)'(LONG_MIN)) begin
            pclass = PER_SHORT;
        end else if (width < (RCW + 1)'(SOF_MIN)) begin
            pclass = PER_LONG;
        end else if (width < (RCW + 1)'(SOF_MAX)) begin
            pclass = PER_SOF;
        end else begin
            pclass = PER_OVER;
        end
    end

    // Decoded value of a data period.
    always_comb begin
        new_bit = vpw_bit_value(pclass == PER_LONG, ended_level);
    end

    // Frame tracking, bit assembly and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame   <= 1'b0;
            shreg      <= '0;
            bitn       <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_invalid <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            rx_invalid <= 1'b0;
            if (edge_seen) begin
                case (pclass)
                    PER_NOISE: begin
                        in_frame <= 1'b0;
                    end
                    PER_SHORT, PER_LONG: begin
                        if (in_frame) begin
                            if (bitn == 3'd7) begin
                                rx_data  <= {shreg, new_bit};
                                rx_valid <= 1'b1;
                                bitn     <= '0;
                            end else begin
                                shreg <= {shreg[5:0], new_bit};
                                bitn  <= bitn + 1'b1;
                            end
                        end
                    end
                    PER_SOF: begin
                        in_frame <= ended_level;
                        bitn     <= '0;
                    end
                    default: begin
                        in_frame <= 1'b0;
                        if (ended_level) begin
                            rx_invalid <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // A byte strobe never lasts more than one cycle.
    assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // A byte and an invalid symbol are never reported together.
    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_invalid}));

    // An invalid symbol always leaves the receiver outside a frame.
    assert_invalid_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_invalid |-> !in_frame);

endmodule

// File: rtl/vpw_codec.sv
// vpw_codec: top of the variable-pulse-width bit codec. Joins the
// transmitter, the bus synchronizer and the receiver. All time constants
// are in ticks of the tick enable; defaults suit a 1 us tick.
module vpw_codec #(
    parameter int SHORT_T   = 64,
    parameter int LONG_T    = 128,
    parameter int SOF_T     = 200,
    parameter int NOISE_MIN = 34,
    parameter int LONG_MIN  = 96,
    parameter int SOF_MIN   = 163,
    parameter int SOF_MAX   = 239
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       bus_tx,
    input  logic       bus_rx,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_invalid
);

    logic edge_seen;
    logic ended_level;

    // Transmit path.
    vpw_tx #(
        .SHORT_T (SHORT_T),
        .LONG_T  (LONG_T),
        .SOF_T   (SOF_T)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .bus_tx   (bus_tx)
    );

    // Bus level synchronizer and edge detector.
    vpw_edge_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_in      (bus_rx),
        .edge_seen   (edge_seen),
        .ended_level (ended_level)
    );

    // Receive path.
    vpw_rx #(
        .NOISE_MIN (NOISE_MIN),
        .LONG_MIN  (LONG_MIN),
        .SOF_MIN   (SOF_MIN),
        .SOF_MAX   (SOF_MAX)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .edge_seen   (edge_seen),
        .ended_level (ended_level),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_invalid  (rx_invalid)
    );

endmodule

// File: tb/sim_vpw_codec.sv
// sim_vpw_codec: directed bench for vpw_codec, one task per scenario.
module sim_vpw_codec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       bus_tx;
    logic       bus_rx;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_invalid;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tdc = 0;
    int cycles = 0;
    logic loop_en = 1'b1;
    logic drv_lvl = 1'b0;

    // Transmit-side recording.
    int   mon_w [64];
    logic mon_l [64];
    int   nw = 0;
    int   run = 0;
    logic prev_tx = 1'b0;
    logic mon_started = 1'b0;

    // Receive-side recording.
    logic [7:0] rx_buf [16];
    int nrx = 0;
    int ninv = 0;

    // Expected transmit widths in ticks.
    int   exp_w [64];
    logic exp_l [64];
    int   ne = 0;
    logic [7:0] tx_q [16];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (tdc + 1 >= tick_div) tdc <= 0;
        else tdc <= tdc + 1;
    end
    assign tick   = (tdc == 0);
    assign bus_rx = loop_en ? bus_tx : drv_lvl;

    vpw_codec u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .bus_tx     (bus_tx),
        .bus_rx     (bus_rx),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_invalid (rx_invalid)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_tx != prev_tx) begin
                if (mon_started && nw < 64) begin
                    mon_w[nw] = run;
                    mon_l[nw] = prev_tx;
                    nw++;
                end
                mon_started = 1'b1;
                run = 1;
            end else begin
                run++;
            end
            prev_tx = bus_tx;
            if (rx_valid && nrx < 16) begin
                rx_buf[nrx] = rx_data;
                nrx++;
            end
            if (rx_invalid) ninv++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_rec();
        nw = 0; ne = 0; nrx = 0; ninv = 0; mon_started = 1'b0;
    endtask

    // Append the widths one byte should produce (R3 table).
    task automatic expect_byte(input logic [7:0] b);
        logic lvl = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            exp_w[ne] = (b[i] == lvl) ? 128 : 64;
            exp_l[ne] = lvl;
            ne++;
            lvl = ~lvl;
        end
    endtask

    task automatic send_frame(input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            tx_valid = 1'b1;
            tx_data  = tx_q[i];
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
        end
        tx_valid = 1'b0;
        while (!(tx_ready && !bus_tx)) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    // Compare the recorded transmit periods with the expected table.
    task automatic check_widths(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < ne; i++) begin
            if (i + 1 >= nw || mon_w[i + 1] != exp_w[i] * tick_div || mon_l[i + 1] != exp_l[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, req, first, -1);
        chk(nw == ne + 1, req, nw, ne + 1);
    endtask

    task automatic drive(input logic lvl, input int ticks);
        drv_lvl = lvl;
        repeat (ticks * tick_div) @(negedge clk);
    endtask

    task automatic drive_bits(input logic [7:0] b, input int sw, input int lw);
        logic lvl = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            drive(lvl, (b[i] == lvl) ? lw : sw);
            lvl = ~lvl;
        end
    endtask

    task automatic t_reset();
        chk(bus_tx == 1'b0, "R1 bus_tx", bus_tx, 0);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(rx_invalid == 1'b0, "R1 rx_invalid", rx_invalid, 0);
    endtask

    task automatic t_single();
        clear_rec();
        tx_q[0] = 8'hA5;
        expect_byte(8'hA5);
        send_frame(1);
        chk(nw > 0 && mon_w[0] == 200 && mon_l[0] == 1'b1, "R2 start pulse width", mon_w[0], 200);
        chk(nw > 1 && mon_l[1] == 1'b0, "R2 first bit passive", mon_l[1], 0);
        check_widths("R3 bit widths 0xA5");
        chk(nrx == 1 && rx_buf[0] == 8'hA5, "R7 loopback byte", rx_buf[0], 8'hA5);
    endtask

    task automatic t_multi();
        clear_rec();
        tx_q[0] = 8'h00; tx_q[1] = 8'hFF; tx_q[2] = 8'h3C;
        for (int i = 0; i < 3; i++) expect_byte(tx_q[i]);
        send_frame(3);
        chk(mon_w[0] == 200, "R4 single start pulse", mon_w[0], 200);
        check_widths("R4 chained bytes");
        chk(nrx == 3, "R6 byte count", nrx, 3);
        for (int i = 0; i < 3; i++)
            chk(rx_buf[i] == tx_q[i], "R6 chained data", rx_buf[i], tx_q[i]);
        chk(tx_ready && !bus_tx, "R4 idle after frame", {tx_ready, bus_tx}, 2);
    endtask

    task automatic t_tick_div();
        clear_rec();
        tick_div = 3;
        tx_q[0] = 8'h5A;
        expect_byte(8'h5A);
        send_frame(1);
        chk(mon_w[0] > 199 * 3 && mon_w[0] <= 600, "R5 start pulse scaled", mon_w[0], 600);
        check_widths("R5 scaled bits");
        chk(nrx == 1 && rx_buf[0] == 8'h5A, "R5 scaled loopback", rx_buf[0], 8'h5A);
        tick_div = 1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_windows();
        clear_rec();
        loop_en = 1'b0;
        @(negedge clk);
        drive(0, 50);
        drive(1, 163);
        drive_bits(8'hC3, 34, 162);
        drive(0, 300);
        drive(1, 238);
        drive_bits(8'h96, 95, 96);
        drive(0, 300);
        chk(nrx == 2, "R6 window byte count", nrx, 2);
        chk(rx_buf[0] == 8'hC3, "R6 edges 34/162 with start 163", rx_buf[0], 8'hC3);
        chk(rx_buf[1] == 8'h96, "R6 edges 95/96 with start 238", rx_buf[1], 8'h96);
        chk(ninv == 0, "R6 no invalid", ninv, 0);
    endtask

    task automatic t_invalid();
        clear_rec();
        drive(1, 250);
        drive_bits(8'h11, 64, 128);
        drive(0, 300);
        chk(ninv == 1, "R9 one-cycle invalid pulse", ninv, 1);
        chk(nrx == 0, "R9 no byte after invalid", nrx, 0);
    endtask

    task automatic t_noise();
        clear_rec();
        drive(1, 200);
        drive(0, 64);
        drive(1, 20);
        drive(0, 64);
        drive(1, 128); drive(0, 64); drive(1, 128);
        drive(0, 64); drive(1, 128); drive(0, 64); drive(1, 128);
        drive(0, 300);
        chk(nrx == 0 && ninv == 0, "R8 noise abandons byte", nrx + ninv, 0);
        drive(1, 200);
        drive_bits(8'h7E, 64, 128);
        drive(0, 300);
        chk(nrx == 1 && rx_buf[0] == 8'h7E, "R8 recovery at next start", rx_buf[0], 8'h7E);
    endtask

    task automatic t_gap();
        clear_rec();
        drive(1, 200);
        drive(0, 64); drive(1, 64); drive(0, 64);
        drive(1, 64);
        drive(0, 170);
        drive(1, 64); drive(0, 64); drive(1, 64); drive(0, 64);
        drive(1, 64); drive(0, 64); drive(1, 64); drive(0, 64);
        drive(0, 300);
        chk(nrx == 0 && ninv == 0, "R10 passive gap ends frame", nrx + ninv, 0);
        loop_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_single();
        t_multi();
        t_tick_div();
        t_windows();
        t_invalid();
        t_noise();
        t_gap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule